// File: doc/BRIEF.md
# Indirect-Window PCS Register Bank

This block holds the 16-bit configuration and status registers of a physical coding sublayer. Software reaches them through a small indirect window rather than a flat map. One fixed location holds a window-select value, and that value picks one of four register groups: a standard control group, a standard media-independent-interface group, a time-synchronisation group and a vendor group. Every other aligned halfword offset in the 8 KiB window then addresses a register inside the group that is currently selected.

All registers are plain storage with power-on defaults. There is one exception. Setting the top bit of the first register of the standard interface group reloads all four groups with their defaults in a single clock. That lets a driver restore a known state without asserting the hardware reset. Reads are answered one clock after the request, and writes produce no response.

Top module: `pcs_window_regs`

## Requirements
- R1: Byte offset 0x1FE always reaches the window-select register, whatever the current selection. A read of it returns the last 16-bit value written, and hardware reset clears it to 0x0000.
- R2: Window-select value 0x1E00 picks the control group, 0x1F00 the standard interface group, 0x1F07 the time-sync group and 0x1F80 the vendor group.
- R3: For any other offset, the register index is the byte address divided by two (address bits 12:1) within the selected group. A write stores the value and a later read returns it.
- R4: With the default parameters the group sizes are 9, 16, 17 and 227 registers. A read at an index at or beyond the selected group's size returns 0x0000, and a write there changes nothing.
- R5: While the window-select register holds any value other than the four in R2, reads outside offset 0x1FE return 0x0000 and writes there change no register.
- R6: A write of a value with bit 15 set to index 0 of the standard interface group reloads all four groups with their defaults in that clock. The window-select register keeps its value, and an access on the very next cycle already sees the defaults (index 0 reads 0x1140).
- R7: After hardware reset, the standard interface group holds 0x1140, 0x0109, 0x699E, 0xCED0 and 0x0020 at indices 0 to 4, 0xC000 at index 15 and zero elsewhere. The control group holds 0x699E at index 4, 0x8000 at index 8 and zero elsewhere.
- R8: The time-sync group defaults are 0x0003 at index 8, 0x0038 at indices 9 and 11, 0x0058 at index 13, 0x0048 at index 15 and zero elsewhere.
- R9: The vendor group defaults include 0x2400 at index 0, 0x000A at index 2, 0x899C at index 6, 0x0019 at index 152 and zero at index 226.
- R10: A read request raises `rsp_valid` for exactly the following cycle, with the data on `rsp_rdata`. A write or an idle cycle leaves `rsp_valid` low in the following cycle, and after hardware reset `rsp_valid` is low.
- R11: A write to index 0 of the standard interface group with bit 15 clear is stored like any other register and triggers no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address in the 8 KiB window (bit 0 ignored, aligned halfword) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 16 | Read data |

## Verification
The bench builds the block with its default group sizes of 9, 16, 17 and 227 registers. With these sizes the last in-range and the first out-of-range index of every group can be reached with short offsets: 0x010/0x012 in the control group, 0x01E/0x020 in the interface group, 0x020/0x022 in the time-sync group and 0x1C4/0x1C6 in the vendor group. The vendor size also keeps every group index below 255, so offset 0x1FE never overlaps group storage. Group contents written before a soft reload are read back afterwards to show that the reload reached groups other than the one being written.

// File: rtl/pcs_win_pkg.sv
package pcs_win_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 16;
    localparam int IDX_W  = ADDR_W - 1;

    localparam logic [IDX_W-1:0]  SEL_REG_IDX = IDX_W'(12'h0FF);
    localparam logic [DATA_W-1:0] SEL_CTL     = 16'h1E00;
    localparam logic [DATA_W-1:0] SEL_MII     = 16'h1F00;
    localparam logic [DATA_W-1:0] SEL_TIM     = 16'h1F07;
    localparam logic [DATA_W-1:0] SEL_VND     = 16'h1F80;
    localparam int                RELOAD_BIT  = 15;

    typedef enum logic [2:0] {
        BK_CTL  = 3'd0,
        BK_MII  = 3'd1,
        BK_TIM  = 3'd2,
        BK_VND  = 3'd3,
        BK_NONE = 3'd4
    } pcs_bank_e;

    typedef struct packed {
        logic              sel_hit;
        pcs_bank_e         bank;
        logic [IDX_W-1:0]  idx;
    } win_dec_t;

    function automatic pcs_bank_e decode_sel(input logic [DATA_W-1:0] sel);
        case (sel)
            SEL_CTL: return BK_CTL;
            SEL_MII: return BK_MII;
            SEL_TIM: return BK_TIM;
            SEL_VND: return BK_VND;
            default: return BK_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] bank_default(input pcs_bank_e bk,
                                                       input int unsigned idx);
        logic [DATA_W-1:0] v;
        v = '0;
        case (bk)
            BK_CTL: case (idx)
                4:       v = 16'h699E;
                8:       v = 16'h8000;
                default: v = '0;
            endcase
            BK_MII: case (idx)
                0:       v = 16'h1140;
                1:       v = 16'h0109;
                2:       v = 16'h699E;
                3:       v = 16'hCED0;
                4:       v = 16'h0020;
                15:      v = 16'hC000;
                default: v = '0;
            endcase
            BK_TIM: case (idx)
                8:       v = 16'h0003;
                9, 11:   v = 16'h0038;
                13:      v = 16'h0058;
                15:      v = 16'h0048;
                default: v = '0;
            endcase
            BK_VND: case (idx)
                0:       v = 16'h2400;
                2:       v = 16'h000A;
                6:       v = 16'h899C;
                16:      v = 16'h0010;
                56:      v = 16'h000A;
                58:      v = 16'h007F;
                61:      v = 16'h0001;
                88:      v = 16'h0100;
                89:      v = 16'h1100;
                93:      v = 16'h000E;
                120:     v = 16'h0100;
                121:     v = 16'h0032;
                136:     v = 16'h0001;
                152:     v = 16'h0019;
                default: v = '0;
            endcase
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pcs_win_decode.sv
module pcs_win_decode
    import pcs_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] sel_q,
    output win_dec_t          dec
);

    logic sel_wr;

    always_comb begin
        dec.idx     = req_addr[ADDR_W-1:1];
        dec.sel_hit = (req_addr[ADDR_W-1:1] == SEL_REG_IDX);
        dec.bank    = decode_sel(sel_q);
    end

    assign sel_wr = req_valid && req_write && dec.sel_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= req_wdata;
        end
    end

    // R1: a write to the select location is held for later reads
    a_r1_sel_holds: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[ADDR_W-1:1] == SEL_REG_IDX)
            |=> sel_q == $past(req_wdata));

    // R1: the select register changes only through its own location
    a_r1_sel_quiet: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_addr[ADDR_W-1:1] == SEL_REG_IDX)
            |=> $stable(sel_q));

endmodule

// File: rtl/pcs_reg_bank.sv
module pcs_reg_bank
    import pcs_win_pkg::*;
#(
    parameter int        DEPTH = 16,
    parameter pcs_bank_e BANK  = BK_MII
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              in_range;

    assign in_range = (idx < LIMIT);

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= bank_default(BANK, i);
            end
        end else if (wr_en && in_range) begin
            mem[idx[IW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (in_range) begin
            rd_data = mem[idx[IW-1:0]];
        end
    end

    // R3: an in-range write lands in the addressed register
    a_r3_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx < LIMIT && !reload)
            |=> mem[$past(idx[IW-1:0])] == $past(wr_data));

    // R6: a reload leaves the first register at its default
    a_r6_reload_first: assert property (@(posedge clk) disable iff (rst)
        reload |=> mem[0] == bank_default(BANK, 0));

endmodule

// File: rtl/pcs_window_regs.sv
module pcs_window_regs
    import pcs_win_pkg::*;
#(
    parameter int CTL_DEPTH = 9,
    parameter int MII_DEPTH = 16,
    parameter int TIM_DEPTH = 17,
    parameter int VND_DEPTH = 227
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int NBANK = 4;
    localparam int BANK_DEPTH [NBANK] = '{CTL_DEPTH, MII_DEPTH, TIM_DEPTH, VND_DEPTH};

    logic [DATA_W-1:0] sel_q;
    win_dec_t          dec;
    logic              bank_acc;
    logic              soft_reload;
    logic [DATA_W-1:0] bank_rd [NBANK];
    logic [DATA_W-1:0] rd_word;

    pcs_win_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_q     (sel_q),
        .dec       (dec)
    );

    assign bank_acc    = req_valid && req_write && !dec.sel_hit;
    assign soft_reload = bank_acc && (dec.bank == BK_MII) &&
                         (dec.idx == '0) && req_wdata[RELOAD_BIT];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        pcs_reg_bank #(
            .DEPTH (BANK_DEPTH[g]),
            .BANK  (pcs_bank_e'(g))
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .reload  (soft_reload),
            .wr_en   (bank_acc && (dec.bank == pcs_bank_e'(g))),
            .idx     (dec.idx),
            .wr_data (req_wdata),
            .rd_data (bank_rd[g])
        );
    end

    always_comb begin
        if (dec.sel_hit) begin
            rd_word = sel_q;
        end else begin
            case (dec.bank)
                BK_CTL:  rd_word = bank_rd[0];
                BK_MII:  rd_word = bank_rd[1];
                BK_TIM:  rd_word = bank_rd[2];
                BK_VND:  rd_word = bank_rd[3];
                default: rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata <= rd_word;
            end
        end
    end

    // R5: reads through an unrecognised selection return zero
    a_r5_bad_sel_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !dec.sel_hit && decode_sel(sel_q) == BK_NONE)
            |=> rsp_rdata == '0);

    // R10: no response follows a write or an idle cycle
    a_r10_no_rsp: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_write) |=> !rsp_valid);

    // R6: a soft reload does not disturb the select register
    a_r6_sel_kept: assert property (@(posedge clk) disable iff (rst)
        soft_reload |=> sel_q == $past(sel_q));

endmodule

// File: tb/test_pcs_window_regs.sv
module test_pcs_window_regs;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [12:0] req_addr;
    logic [15:0] req_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcs_window_regs i_pcs_window_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // {write, requirement, byte address, data / expected value}
    localparam int NV = 54;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 4'd1,  13'h1FE, 16'h0000},  // R1 select resets to 0
        {1'b0, 4'd5,  13'h000, 16'h0000},  // R5 invalid select reads 0
        {1'b1, 4'd2,  13'h1FE, 16'h1F00},  // R2 pick interface group
        {1'b0, 4'd1,  13'h1FE, 16'h1F00},  // R1 readback
        {1'b0, 4'd7,  13'h000, 16'h1140},  // R7
        {1'b0, 4'd7,  13'h002, 16'h0109},  // R7
        {1'b0, 4'd7,  13'h004, 16'h699E},  // R7
        {1'b0, 4'd7,  13'h006, 16'hCED0},  // R7
        {1'b0, 4'd7,  13'h008, 16'h0020},  // R7
        {1'b0, 4'd7,  13'h01E, 16'hC000},  // R7 last index
        {1'b1, 4'd3,  13'h008, 16'hABCD},  // R3 store
        {1'b0, 4'd3,  13'h008, 16'hABCD},  // R3 readback
        {1'b1, 4'd4,  13'h020, 16'h1234},  // R4 write past end
        {1'b0, 4'd4,  13'h020, 16'h0000},  // R4 still zero
        {1'b0, 4'd3,  13'h01C, 16'h0000},  // R3 in-range default zero
        {1'b1, 4'd2,  13'h1FE, 16'h1E00},  // R2 control group
        {1'b0, 4'd7,  13'h008, 16'h699E},  // R7
        {1'b0, 4'd7,  13'h010, 16'h8000},  // R7 last index
        {1'b0, 4'd4,  13'h012, 16'h0000},  // R4 first out of range
        {1'b1, 4'd2,  13'h1FE, 16'h1F07},  // R2 time-sync group
        {1'b0, 4'd8,  13'h010, 16'h0003},  // R8
        {1'b0, 4'd8,  13'h012, 16'h0038},  // R8
        {1'b0, 4'd8,  13'h016, 16'h0038},  // R8
        {1'b0, 4'd8,  13'h01A, 16'h0058},  // R8
        {1'b0, 4'd8,  13'h01E, 16'h0048},  // R8
        {1'b0, 4'd8,  13'h014, 16'h0000},  // R8 zero between
        {1'b0, 4'd8,  13'h020, 16'h0000},  // R8 last index zero
        {1'b0, 4'd4,  13'h022, 16'h0000},  // R4 first out of range
        {1'b1, 4'd2,  13'h1FE, 16'h1F80},  // R2 vendor group
        {1'b0, 4'd9,  13'h000, 16'h2400},  // R9
        {1'b0, 4'd9,  13'h00C, 16'h899C},  // R9
        {1'b0, 4'd9,  13'h130, 16'h0019},  // R9
        {1'b0, 4'd9,  13'h1C4, 16'h0000},  // R9 last index
        {1'b1, 4'd3,  13'h1C4, 16'h5555},  // R3 store at last index
        {1'b0, 4'd3,  13'h1C4, 16'h5555},  // R3
        {1'b1, 4'd4,  13'h1C6, 16'h7777},  // R4 write past end
        {1'b0, 4'd4,  13'h1C6, 16'h0000},  // R4
        {1'b1, 4'd5,  13'h1FE, 16'h1F01},  // R5 invalid select
        {1'b1, 4'd5,  13'h000, 16'hFFFF},  // R5 ignored write
        {1'b0, 4'd5,  13'h000, 16'h0000},  // R5 reads 0
        {1'b0, 4'd1,  13'h1FE, 16'h1F01},  // R1 any value held
        {1'b1, 4'd5,  13'h1FE, 16'h1F80},  // R5 back to vendor
        {1'b0, 4'd5,  13'h000, 16'h2400},  // R5 vendor untouched
        {1'b1, 4'd2,  13'h1FE, 16'h1F00},  // R2
        {1'b1, 4'd11, 13'h000, 16'h0100},  // R11 plain control write
        {1'b0, 4'd11, 13'h000, 16'h0100},  // R11 stored
        {1'b0, 4'd11, 13'h008, 16'hABCD},  // R11 no reload
        {1'b1, 4'd6,  13'h000, 16'h9000},  // R6 soft reload
        {1'b0, 4'd6,  13'h000, 16'h1140},  // R6 next cycle default
        {1'b0, 4'd6,  13'h008, 16'h0020},  // R6 other register reloaded
        {1'b0, 4'd6,  13'h1FE, 16'h1F00},  // R6 select kept
        {1'b1, 4'd6,  13'h1FE, 16'h1F80},  // R6
        {1'b0, 4'd6,  13'h1C4, 16'h0000},  // R6 vendor reloaded
        {1'b0, 4'd6,  13'h000, 16'h2400}   // R6
    };

    task automatic check(input int rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic access(input logic w, input int rq, input logic [12:0] a,
                          input logic [15:0] d);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = w ? d : 16'h0;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        if (w) begin
            check(10, {15'h0, rsp_valid}, 16'h0);  // R10 no response to write
        end else begin
            check(10, {15'h0, rsp_valid}, 16'h1);  // R10 response one cycle later
            check(rq, rsp_rdata, d);
        end
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        check(10, {15'h0, rsp_valid}, 16'h0);  // R10 reset state
        check(10, rsp_rdata, 16'h0);           // R10 reset state
        rst = 1'b0;
        @(negedge clk);
        check(10, {15'h0, rsp_valid}, 16'h0);  // R10 idle keeps it low

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][33], int'(VEC[i][32:29]), VEC[i][28:16], VEC[i][15:0]);
        end

        // R7: hardware reset mid-run restores defaults and clears select (R1)
        access(1'b1, 3, 13'h1FE, 16'h1F00);
        access(1'b1, 3, 13'h008, 16'h1111);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b0, 1, 13'h1FE, 16'h0000);
        access(1'b1, 2, 13'h1FE, 16'h1F00);
        access(1'b0, 7, 13'h008, 16'h0020);

        // R6: reload triggered then a read of the time-sync group
        access(1'b1, 2, 13'h1FE, 16'h1F07);
        access(1'b1, 3, 13'h012, 16'h4242);
        access(1'b1, 2, 13'h1FE, 16'h1F00);
        access(1'b1, 6, 13'h000, 16'h8000);
        access(1'b1, 2, 13'h1FE, 16'h1F07);
        access(1'b0, 6, 13'h012, 16'h0038);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule